// File: doc/BRIEF.md
# Cross-Stream Commonality Detector and Vote Aligner

This block sits between three unsynchronised input streams and three redundant processing elements. Each stream has its own first-in first-out buffer. The head of each buffer is offered to its element as the active operand word. Every buffer can also be searched by content. At any moment, the active word of one stream is compared against every word still waiting in the other two buffers. A match marks that word as common to more than one stream, so the redundant elements can be compared on it later even though they never ran in lockstep.

When an element consumes an active word that is common, the word and that element's result are stored in a small cache of common symbols. Each cached symbol has one result slot per element. The other elements fill their slots whenever they reach the same word in their own streams. Once all three slots are filled, the block offers the word and the three results, lined up in stream order, as a vote request on a valid/ready handshake. The entry is freed when the request is accepted.

If the cache has no free entry, a new common word is dropped and a saturating drop counter advances. The streams never stall because of this.

Top module: `xstream_vote_align`

## Requirements
- R1: After synchronous reset, every buffer is empty: `in_ready` is all ones, while `act_valid`, `hit`, `vote_valid` and `drop_count` are zero.
- R2: Each stream buffer holds up to 32 words. `in_ready[s]` is low exactly when 32 words are stored. A push offered while `in_ready[s]` is low is ignored.
- R3: `act_valid[s]` is high when stream s holds a word, and `act_data[s]` is its oldest word. `pe_take[s]` with `act_valid[s]` removes that word, and words leave in arrival order. `pe_take[s]` while `act_valid[s]` is low has no effect.
- R4: `hit[s]` is high exactly when `act_valid[s]` is high and `act_data[s]` equals some word stored, at the start of the cycle, in the buffer of another stream.
- R5: Suppose element s consumes a word with `hit[s]` high, the word is not cached, and an entry is free. The lowest-index free entry is then allocated, holding the word and `pe_result[s]` in slot s.
- R6: When element s consumes a word that is already cached, whether or not `hit[s]` is high, `pe_result[s]` fills slot s of that entry if the slot is empty. A filled slot keeps its first value, and no second entry is made for the same word.
- R7: If element s consumes a word with `hit[s]` high, the word is not cached and all 4 entries are in use, the word is dropped. `drop_count` rises by one and saturates at its all-ones value. Otherwise `drop_count` holds.
- R8: `vote_valid` is high while some entry has all three slots filled. The offer is the lowest-index complete entry: `vote_pattern` is its word and `vote_results[s]` holds element s's result.
- R9: While `vote_valid` is high and `vote_ready` is low, the offered word and results stay unchanged on the next cycle. When the offer is accepted, its entry is freed at that clock edge.
- R10: Within one cycle, the freeing of an accepted entry is applied first. The consumptions of streams 0, 1 and 2 are then applied in that order, so two or three streams consuming the same new common word in one cycle share a single entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 3 | Per-stream push request |
| in_data | input | 3x32 | Per-stream pushed word (two 16-bit operands) |
| in_ready | output | 3 | Per-stream buffer has room |
| act_valid | output | 3 | Per-stream active word present |
| act_data | output | 3x32 | Per-stream active word |
| pe_take | input | 3 | Element consumes its active word |
| pe_result | input | 3x32 | Element result for the word consumed this cycle |
| hit | output | 3 | Active word also waits in another stream |
| vote_valid | output | 1 | Aligned vote request offered |
| vote_ready | input | 1 | Vote request accepted |
| vote_pattern | output | 32 | Common word of the offered request |
| vote_results | output | 3x32 | Three aligned results, index = stream |
| drop_count | output | 8 | Saturating count of dropped common words |

## Verification
On every cycle, the embedded properties check four things: a full buffer refuses pushes, an offer stays steady under back-pressure, the drop counter moves only when a consumed word hits, and no word ever occupies two cache entries. Other behaviours need the bench's behavioural model, compared on every clock. These are the choice of which entry is allocated or offered, slots keeping their first result, the order of same-cycle updates, and the content search across buffers. Directed scenarios drive a buffer past full, fill the cache until a drop occurs, and complete several entries at once while the voter stalls. One scenario has all three streams consume one word together. A long pseudo-random phase with a small alphabet then mixes all of these.

// File: rtl/xva_pkg.sv
package xva_pkg;
    localparam int NS = 3;
    localparam int DW = 32;

    typedef logic [DW-1:0] word_t;

    typedef struct packed {
        logic                  live;
        logic [NS-1:0]         have;
        word_t                 key;
        logic [NS-1:0][DW-1:0] res;
    } slot_t;

    function automatic int lowest_set(input logic [31:0] v, input int n);
        int r;
        r = 0;
        for (int i = n - 1; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction
endpackage

// File: rtl/stream_fifo.sv
module stream_fifo
    import xva_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int SELF  = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  push_valid,
    input  word_t                 push_data,
    output logic                  push_ready,
    output logic                  head_valid,
    output word_t                 head_data,
    input  logic                  take,
    input  logic [NS-1:0][DW-1:0] keys,
    output logic [NS-1:0]         key_hit
);
    localparam int AW = $clog2(DEPTH);

    word_t          mem [DEPTH];
    logic [AW-1:0]  rd_q, wr_q;
    logic [AW:0]    cnt_q;
    logic           full, push_ok, take_ok;
    logic [DEPTH-1:0] occ;

    assign full       = (cnt_q == (AW+1)'(DEPTH));
    assign push_ready = !full;
    assign head_valid = (cnt_q != '0);
    assign head_data  = mem[rd_q];
    assign push_ok    = push_valid && !full;
    assign take_ok    = take && head_valid;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wr_q <= wr_q + 1'b1;
            if (take_ok) rd_q <= rd_q + 1'b1;
            cnt_q <= cnt_q + (AW+1)'(push_ok) - (AW+1)'(take_ok);
        end
    end

    // occupancy of each storage slot relative to the read pointer
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic [AW-1:0] off;
            off    = AW'(i) - rd_q;
            occ[i] = ({1'b0, off} < cnt_q);
        end
    end

    // content search of all stored words against each stream's active word
    for (genvar k = 0; k < NS; k++) begin : g_key
        if (k == SELF) begin : g_self
            assign key_hit[k] = 1'b0;
        end else begin : g_other
            always_comb begin
                key_hit[k] = 1'b0;
                for (int i = 0; i < DEPTH; i++) begin
                    if (occ[i] && mem[i] == keys[k]) key_hit[k] = 1'b1;
                end
            end
        end
    end

    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (push_valid && full && !take) |=> $stable(cnt_q));
endmodule

// File: rtl/symbol_cache.sv
module symbol_cache
    import xva_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int CW      = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NS-1:0]         pop,
    input  logic [NS-1:0][DW-1:0] pat,
    input  logic [NS-1:0][DW-1:0] res_in,
    input  logic [NS-1:0]         hit,
    input  logic                  vote_ready,
    output logic                  vote_valid,
    output word_t                 vote_key,
    output logic [NS-1:0][DW-1:0] vote_res,
    output logic [CW-1:0]         drop_count
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [CW-1:0] DMAX = '1;

    slot_t               tab_q [ENTRIES];
    slot_t               tab_d [ENTRIES];
    logic                hold_q;
    logic [IW-1:0]       hold_idx_q, sel_idx;
    logic [CW-1:0]       drop_q, drop_d;
    logic [1:0]          drop_inc;
    logic [ENTRIES-1:0]  done_v, free_v;
    logic                found;
    logic [IW-1:0]       pos;
    logic [CW:0]         drop_sum;

    always_comb begin
        for (int e = 0; e < ENTRIES; e++) done_v[e] = tab_q[e].live && (&tab_q[e].have);
    end

    assign sel_idx    = hold_q ? hold_idx_q : IW'(lowest_set(32'(done_v), ENTRIES));
    assign vote_valid = |done_v;
    assign vote_key   = tab_q[sel_idx].key;
    assign vote_res   = tab_q[sel_idx].res;
    assign drop_count = drop_q;

    // free the accepted entry, then apply streams 0..NS-1 in order
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) tab_d[e] = tab_q[e];
        drop_inc = '0;
        found    = 1'b0;
        pos      = '0;
        free_v   = '0;
        if (vote_valid && vote_ready) begin
            tab_d[sel_idx].live = 1'b0;
            tab_d[sel_idx].have = '0;
        end
        for (int s = 0; s < NS; s++) begin
            if (pop[s]) begin
                found = 1'b0;
                pos   = '0;
                for (int e = 0; e < ENTRIES; e++) begin
                    if (tab_d[e].live && tab_d[e].key == pat[s]) begin
                        found = 1'b1;
                        pos   = IW'(e);
                    end
                end
                if (found) begin
                    if (!tab_d[pos].have[s]) begin
                        tab_d[pos].have[s] = 1'b1;
                        tab_d[pos].res[s]  = res_in[s];
                    end
                end else if (hit[s]) begin
                    for (int e = 0; e < ENTRIES; e++) free_v[e] = !tab_d[e].live;
                    if (|free_v) begin
                        pos                = IW'(lowest_set(32'(free_v), ENTRIES));
                        tab_d[pos].live    = 1'b1;
                        tab_d[pos].key     = pat[s];
                        tab_d[pos].have    = '0;
                        tab_d[pos].have[s] = 1'b1;
                        tab_d[pos].res     = '0;
                        tab_d[pos].res[s]  = res_in[s];
                    end else begin
                        drop_inc = drop_inc + 2'd1;
                    end
                end
            end
        end
        drop_sum = {1'b0, drop_q} + (CW+1)'(drop_inc);
        drop_d   = (drop_sum > {1'b0, DMAX}) ? DMAX : drop_sum[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) tab_q[e] <= '0;
            hold_q     <= 1'b0;
            hold_idx_q <= '0;
            drop_q     <= '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) tab_q[e] <= tab_d[e];
            hold_q     <= vote_valid && !vote_ready;
            hold_idx_q <= sel_idx;
            drop_q     <= drop_d;
        end
    end

    // R9
    offer_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (vote_valid && !vote_ready) |=> (vote_valid && $stable(vote_key) && $stable(vote_res)));

    // R7
    drop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (~|(pop & hit)) |=> $stable(drop_count));

    for (genvar a = 0; a < ENTRIES; a++) begin : g_da
        for (genvar b = a + 1; b < ENTRIES; b++) begin : g_db
            // R6
            single_entry_chk: assert property (@(posedge clk) disable iff (rst)
                !(tab_q[a].live && tab_q[b].live && tab_q[a].key == tab_q[b].key));
        end
    end
endmodule

// File: rtl/xstream_vote_align.sv
module xstream_vote_align
    import xva_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int ENTRIES = 4,
    parameter int CNT_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NS-1:0]         in_valid,
    input  logic [NS-1:0][DW-1:0] in_data,
    output logic [NS-1:0]         in_ready,
    output logic [NS-1:0]         act_valid,
    output logic [NS-1:0][DW-1:0] act_data,
    input  logic [NS-1:0]         pe_take,
    input  logic [NS-1:0][DW-1:0] pe_result,
    output logic [NS-1:0]         hit,
    output logic                  vote_valid,
    input  logic                  vote_ready,
    output logic [DW-1:0]         vote_pattern,
    output logic [NS-1:0][DW-1:0] vote_results,
    output logic [CNT_W-1:0]      drop_count
);
    logic [NS-1:0][NS-1:0] kh;
    logic [NS-1:0]         seen;
    logic [NS-1:0]         pop;

    for (genvar s = 0; s < NS; s++) begin : g_stream
        stream_fifo #(.DEPTH(DEPTH), .SELF(s)) u_fifo (
            .clk        (clk),
            .rst        (rst),
            .push_valid (in_valid[s]),
            .push_data  (in_data[s]),
            .push_ready (in_ready[s]),
            .head_valid (act_valid[s]),
            .head_data  (act_data[s]),
            .take       (pe_take[s]),
            .keys       (act_data),
            .key_hit    (kh[s])
        );
    end

    // a stream's active word is common if any other buffer reports it
    always_comb begin
        seen = '0;
        for (int s = 0; s < NS; s++) begin
            for (int t = 0; t < NS; t++) seen[s] = seen[s] | kh[t][s];
        end
    end

    assign hit = seen & act_valid;
    assign pop = pe_take & act_valid;

    symbol_cache #(.ENTRIES(ENTRIES), .CW(CNT_W)) u_cache (
        .clk        (clk),
        .rst        (rst),
        .pop        (pop),
        .pat        (act_data),
        .res_in     (pe_result),
        .hit        (hit),
        .vote_ready (vote_ready),
        .vote_valid (vote_valid),
        .vote_key   (vote_pattern),
        .vote_res   (vote_results),
        .drop_count (drop_count)
    );
endmodule

// File: tb/xstream_vote_align_bench.sv
module xstream_vote_align_bench;
    import xva_pkg::*;

    localparam int DEPTH = 32;
    localparam int ENT   = 4;
    localparam int CW    = 8;

    logic clk = 1'b0;
    logic rst;
    always #2 clk = ~clk;

    logic [NS-1:0]         in_valid, in_ready, act_valid, pe_take, hit;
    logic [NS-1:0][DW-1:0] in_data, act_data, pe_result, vote_results;
    logic                  vote_valid, vote_ready;
    logic [DW-1:0]         vote_pattern;
    logic [CW-1:0]         drop_count;

    xstream_vote_align #(.DEPTH(DEPTH), .ENTRIES(ENT), .CNT_W(CW)) u_xstream_vote_align (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .act_valid(act_valid), .act_data(act_data), .pe_take(pe_take), .pe_result(pe_result),
        .hit(hit), .vote_valid(vote_valid), .vote_ready(vote_ready), .vote_pattern(vote_pattern),
        .vote_results(vote_results), .drop_count(drop_count)
    );

    int checks = 0;
    int fails  = 0;

    // behavioural model state
    word_t    mb [NS][DEPTH];
    int       mn [NS];
    bit       ml [ENT];
    bit [2:0] mh [ENT];
    word_t    mk [ENT];
    word_t    mr [ENT][NS];
    int       mdrop;
    bit       mheld;
    int       mhi;

    // drive values for the next cycle
    bit [2:0] drv_pv, drv_tk;
    bit       drv_vr;
    word_t    drv_pd [NS];
    word_t    tweak [NS];

    function automatic word_t pe_fn(int s, word_t v);
        word_t r;
        r = 32'(v[31:16]) * 32'(v[15:0]);
        if (s == 1 && v[3:0] == 4'h5) r = r | 32'h8000_0000;
        if (s == 2 && v[0]) r = r ^ 32'h20;
        return r;
    endfunction

    function automatic bit mhit(int s);
        if (mn[s] == 0) return 1'b0;
        for (int t = 0; t < NS; t++) begin
            if (t != s) begin
                for (int j = 0; j < mn[t]; j++) if (mb[t][j] == mb[s][0]) return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        bit [2:0] pops, hits, acc;
        word_t    heads [NS];
        word_t    rv [NS];
        bit       vv;
        int       sel, f, fr;
        @(negedge clk);
        in_valid   = drv_pv;
        pe_take    = drv_tk;
        vote_ready = drv_vr;
        for (int s = 0; s < NS; s++) begin
            in_data[s]   = drv_pd[s];
            rv[s]        = (mn[s] > 0) ? (pe_fn(s, mb[s][0]) ^ tweak[s]) : '0;
            pe_result[s] = rv[s];
        end
        #1;
        vv  = 1'b0;
        sel = 0;
        for (int e = ENT - 1; e >= 0; e--) if (ml[e] && mh[e] == 3'b111) begin vv = 1'b1; sel = e; end
        if (mheld) sel = mhi;
        for (int s = 0; s < NS; s++) begin
            chk("R2", "in_ready", 64'(in_ready[s]), 64'(mn[s] < DEPTH));
            chk("R3", "act_valid", 64'(act_valid[s]), 64'(mn[s] > 0));
            if (mn[s] > 0) chk("R3", "act_data", 64'(act_data[s]), 64'(mb[s][0]));
            chk("R4", "hit", 64'(hit[s]), 64'(mhit(s)));
        end
        chk("R8", "vote_valid", 64'(vote_valid), 64'(vv));
        if (vv) begin
            chk("R8", "vote_pattern", 64'(vote_pattern), 64'(mk[sel]));
            for (int s = 0; s < NS; s++) chk("R8", "vote_results", 64'(vote_results[s]), 64'(mr[sel][s]));
        end
        chk("R7", "drop_count", 64'(drop_count), 64'(mdrop));
        // model update for the coming edge
        for (int s = 0; s < NS; s++) begin
            pops[s]  = drv_tk[s] && mn[s] > 0;
            heads[s] = mb[s][0];
            hits[s]  = mhit(s);
            acc[s]   = drv_pv[s] && mn[s] < DEPTH;
        end
        if (vv && drv_vr) begin ml[sel] = 1'b0; mh[sel] = '0; end
        for (int s = 0; s < NS; s++) begin
            if (pops[s]) begin
                f = -1;
                for (int e = 0; e < ENT; e++) if (ml[e] && mk[e] == heads[s]) f = e;
                if (f >= 0) begin
                    if (!mh[f][s]) begin mh[f][s] = 1'b1; mr[f][s] = rv[s]; end
                end else if (hits[s]) begin
                    fr = -1;
                    for (int e = 0; e < ENT; e++) if (!ml[e] && fr < 0) fr = e;
                    if (fr >= 0) begin
                        ml[fr] = 1'b1; mk[fr] = heads[s]; mh[fr] = '0;
                        mh[fr][s] = 1'b1; mr[fr][s] = rv[s];
                    end else if (mdrop < 255) begin
                        mdrop++;
                    end
                end
            end
        end
        mheld = vv && !drv_vr;
        mhi   = sel;
        for (int s = 0; s < NS; s++) begin
            if (pops[s]) begin
                for (int j = 0; j < DEPTH - 1; j++) mb[s][j] = mb[s][j+1];
                mn[s]--;
            end
            if (acc[s]) begin mb[s][mn[s]] = drv_pd[s]; mn[s]++; end
        end
    endtask

    task automatic idle(bit vr);
        drv_pv = '0; drv_tk = '0; drv_vr = vr;
        step();
    endtask

    function automatic word_t pb(int k);
        return {16'(k + 20), 16'(k + 40)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit [31:0] lf;
        rst = 1'b1;
        in_valid = '0; pe_take = '0; vote_ready = 1'b0; in_data = '0; pe_result = '0;
        drv_pv = '0; drv_tk = '0; drv_vr = 1'b0;
        for (int s = 0; s < NS; s++) begin mn[s] = 0; drv_pd[s] = '0; tweak[s] = '0; end
        for (int e = 0; e < ENT; e++) begin ml[e] = 1'b0; mh[e] = '0; end
        mdrop = 0; mheld = 1'b0; mhi = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "in_ready", 64'(in_ready), 64'h7);
        chk("R1", "act_valid", 64'(act_valid), 64'h0);
        chk("R1", "hit", 64'(hit), 64'h0);
        chk("R1", "vote_valid", 64'(vote_valid), 64'h0);
        chk("R1", "drop_count", 64'(drop_count), 64'h0);

        // R2, R3: overfill stream 0, then drain it past empty
        for (int k = 0; k < 33; k++) begin
            drv_pv = 3'b001; drv_pd[0] = 32'h0100_0000 + 32'(k); drv_tk = '0; drv_vr = 1'b0;
            step();
        end
        idle(1'b0);
        chk("R2", "in_ready full", 64'(in_ready[0]), 64'h0);
        for (int k = 0; k < 34; k++) begin
            drv_pv = '0; drv_tk = 3'b001; drv_vr = 1'b0;
            step();
        end
        chk("R3", "act_valid drained", 64'(act_valid[0]), 64'h0);

        // R5, R7: five common words consumed by stream 0, four entries
        for (int k = 1; k <= 5; k++) begin
            drv_pv = 3'b011; drv_pd[0] = pb(k); drv_pd[1] = pb(k); drv_tk = '0; drv_vr = 1'b0;
            step();
        end
        for (int k = 1; k <= 5; k++) begin
            drv_pv = '0; drv_tk = 3'b001; drv_vr = 1'b0;
            step();
        end
        idle(1'b0);
        chk("R7", "drop after full cache", 64'(drop_count), 64'h1);

        // R6: second consumption of a cached word keeps the first result
        drv_pv = 3'b001; drv_pd[0] = pb(1); drv_tk = '0; step();
        tweak[0] = 32'hDEAD_0000;
        drv_pv = '0; drv_tk = 3'b001; step();
        tweak[0] = '0;

        // R8, R9: complete all four entries under back-pressure
        for (int k = 1; k <= 4; k++) begin
            drv_pv = 3'b100; drv_pd[2] = pb(k); drv_tk = '0; drv_vr = 1'b0;
            step();
        end
        for (int k = 1; k <= 4; k++) begin
            drv_pv = '0; drv_tk = 3'b110; drv_vr = 1'b0;
            step();
        end
        idle(1'b0);
        chk("R9", "held lowest offer", 64'(vote_pattern), 64'(pb(1)));
        chk("R6", "first result kept", 64'(vote_results[0]), 64'(pe_fn(0, pb(1))));
        for (int k = 0; k < 4; k++) idle(1'b1);
        idle(1'b0);
        chk("R9", "all accepted", 64'(vote_valid), 64'h0);
        drv_pv = '0; drv_tk = 3'b010; drv_vr = 1'b0; step();
        idle(1'b0);
        chk("R7", "no drop without hit", 64'(drop_count), 64'h1);

        // R10: all three streams consume one new common word together
        drv_pv = 3'b111;
        for (int s = 0; s < NS; s++) drv_pd[s] = 32'h0033_0044;
        drv_tk = '0; step();
        drv_pv = '0; drv_tk = 3'b111; step();
        idle(1'b0);
        chk("R10", "shared entry complete", 64'(vote_valid), 64'h1);
        chk("R10", "shared entry word", 64'(vote_pattern), 64'h0033_0044);
        idle(1'b1);
        idle(1'b0);
        chk("R9", "freed after accept", 64'(vote_valid), 64'h0);

        // mixed pseudo-random traffic over a small alphabet
        lf = 32'h1ACE_B00C;
        for (int c = 0; c < 3000; c++) begin
            for (int s = 0; s < NS; s++) begin
                lf = (lf << 1) ^ (lf[31] ? 32'h04C1_1DB7 : 32'h0);
                drv_pd[s] = {16'(lf[7:0] % 6 + 3), 16'((lf[7:0] % 6) * 7 + 1)};
                drv_pv[s] = lf[9] | lf[12];
                drv_tk[s] = lf[10] | lf[14];
            end
            drv_vr = lf[11] | lf[13];
            step();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule